// File: doc/BRIEF.md
# Subword Shift and Permute Unit

This block rearranges bits and lanes of a 64-bit word. It treats each operand as a row of lanes of 1, 2, 4 or 8 bytes. It can shift every lane left or right by one shared immediate amount. It can also shift every lane by its own amount, taken from the matching lane of the second operand. Three further operations mix two registers. A funnel shift joins both sources into one double-width value, shifts it right and keeps the lower word. Two interleave operations alternate lanes taken from the two sources. A register-driven permute places any byte or 2-byte lane of the first source in any result position, and a source lane may appear more than once.

The datapath itself is combinational. It sits in front of a single output register with a valid/ready handshake. An operation is accepted on a cycle where both `in_valid` and `in_ready` are high, and its result is presented on `out_valid`/`out_data` from the next cycle on. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. When the consumer holds `out_ready` low, the result stays in place unchanged and no new operation is taken. Nothing is ever dropped or overwritten.

Top module: `ssp_unit`

## Requirements
- R1: Opcode 0 shifts each lane left and opcode 1 shifts each lane right with zero fill, both by `in_imm`. An amount equal to or larger than the lane width gives a zero lane.
- R2: Opcode 2 shifts each lane right arithmetically by `in_imm`. An amount equal to or larger than the lane width gives a lane filled with copies of its sign bit.
- R3: Opcodes 3 (left), 4 (logical right) and 5 (arithmetic right) use the unsigned value of the same lane of `in_b` as that lane's amount. Oversized amounts behave as in R1 and R2.
- R4: Opcode 6 returns the low 64 bits of the 128-bit value {`in_a`,`in_b`} (`in_a` in the upper half) shifted right by `in_imm`.
- R5: Opcode 6 with `in_a` equal to `in_b` returns `in_a` rotated right by `in_imm` bits.
- R6: Opcode 7 (interleave high) works on each pair of lanes 2j+1 and 2j. Result lane 2j+1 takes lane 2j+1 of `in_a`, and result lane 2j takes lane 2j+1 of `in_b`.
- R7: Opcode 8 (interleave low) works on the same lane pairs. Result lane 2j+1 takes lane 2j of `in_a`, and result lane 2j takes lane 2j of `in_b`. With 8-byte lanes, both interleave opcodes return zero.
- R8: Opcode 9 permutes lanes, and repeated indices are allowed. With 1-byte lanes, result byte i is byte `in_b[3i+2:3i]` of `in_a`. With any other lane size, result 2-byte lane i is 2-byte lane `in_b[2i+1:2i]` of `in_a`.
- R9: Lane size code `in_size` selects the lane width: 0 gives 1 byte, 1 gives 2 bytes, 2 gives 4 bytes and 3 gives 8 bytes. Lane 0 is the least significant lane. Opcodes 10 to 15 return zero.
- R10: An operation accepted with `in_valid` and `in_ready` high appears with `out_valid` high on the next cycle. `in_ready` is high whenever `out_valid` is low or `out_ready` is high.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R12: While `rst_n` is low and on the cycle after it is released, `out_valid` is low.
- R13: Interleaving with 2-byte lanes (opcodes 7 and 8) and then with 4-byte lanes transposes each 4x4 quadrant of an 8x8 block of 2-byte values stored two words per row. Swapping the off-diagonal quadrants then gives the full 8x8 transpose.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit can take an operation this cycle |
| in_a | input | 64 | First source word |
| in_b | input | 64 | Second source word (lane amounts, low funnel half or permute indices) |
| in_op | input | 4 | Opcode |
| in_size | input | 2 | Lane size code |
| in_imm | input | 6 | Immediate shift amount |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 64 | Result word |

## Verification
The bench targets the following corner cases.
- Shift amounts exactly at the lane width and just below it, and per-lane amounts whose upper bits are set. A design that compared only the low amount bits would wrap these amounts around instead of returning zero or the sign fill.
- Funnel amounts of 0 and 63, and equal sources. An off-by-one in the concatenation order would show up here as a rotate left or as leakage from the wrong half.
- Interleaves at every lane size. Swapped odd and even lanes would break the 8x8 transpose that the bench rebuilds from the unit's own results.
- Permutes with repeated indices, and output back-pressure. A register that reloads while stalled would change or lose a held result.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;

  localparam int OP_W   = 4;
  localparam int SIZE_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_SHL_I  = 4'd0,
    OP_SHR_I  = 4'd1,
    OP_SAR_I  = 4'd2,
    OP_SHL_V  = 4'd3,
    OP_SHR_V  = 4'd4,
    OP_SAR_V  = 4'd5,
    OP_FUNNEL = 4'd6,
    OP_MIX_HI = 4'd7,
    OP_MIX_LO = 4'd8,
    OP_PERM   = 4'd9
  } ssp_op_e;

  typedef enum logic [SIZE_W-1:0] {
    LS_B1 = 2'd0,
    LS_B2 = 2'd1,
    LS_B4 = 2'd2,
    LS_B8 = 2'd3
  } ssp_size_e;

endpackage

// File: rtl/ssp_lane_shift.sv
`timescale 1ns/1ps
// Per-lane shifter: left, logical right or arithmetic right; amount from the
// immediate or from the matching lane of the second operand.
module ssp_lane_shift #(
  parameter int DATA_W = 64,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [SH_W-1:0]   imm,
  input  logic [1:0]        size,
  input  logic              go_left,
  input  logic              arith,
  input  logic              use_var,
  output logic [DATA_W-1:0] y
);
  localparam int NUM_SIZES = 4;

  logic [DATA_W-1:0] by_size [NUM_SIZES];

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_sz
    localparam int W     = 8 << s;
    localparam int LANES = DATA_W / W;
    localparam int SW    = $clog2(W);

    logic [DATA_W-1:0] r_all;

    for (genvar l = 0; l < LANES; l++) begin : g_ln
      logic [W-1:0]  av;
      logic [W-1:0]  bv;
      logic [W-1:0]  amt;
      logic [SW-1:0] sh;
      logic          oversize;
      logic          fill;
      logic [W-1:0]  r;

      always_comb begin
        av       = a[l*W +: W];
        bv       = b[l*W +: W];
        amt      = use_var ? bv : W'(imm);
        oversize = (amt >= W'(W));
        sh       = amt[SW-1:0];
        fill     = arith & av[W-1];
        if (go_left) begin
          r = oversize ? '0 : (av << sh);
        end else if (oversize) begin
          r = {W{fill}};
        end else if (arith) begin
          r = W'($signed(av) >>> sh);
        end else begin
          r = av >> sh;
        end
      end

      assign r_all[l*W +: W] = r;
    end

    assign by_size[s] = r_all;
  end

  assign y = by_size[size];

endmodule

// File: rtl/ssp_funnel.sv
`timescale 1ns/1ps
// Double-width right shift of {hi,lo}, keeping the low word.
module ssp_funnel #(
  parameter int DATA_W = 64,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] hi,
  input  logic [DATA_W-1:0] lo,
  input  logic [SH_W-1:0]   amt,
  output logic [DATA_W-1:0] y
);
  localparam int CAT_W = 2 * DATA_W;

  logic [CAT_W-1:0] cat;

  assign cat = {hi, lo} >> amt;
  assign y   = DATA_W'(cat);

endmodule

// File: rtl/ssp_mix.sv
`timescale 1ns/1ps
// Lane interleave: for each lane pair, pick the upper (take_hi) or lower lane
// of both sources; first source goes to the upper position of the pair.
module ssp_mix #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [1:0]        size,
  input  logic              take_hi,
  output logic [DATA_W-1:0] y
);
  localparam int MIX_SIZES = 3;

  logic [DATA_W-1:0] by_size [MIX_SIZES];

  for (genvar s = 0; s < MIX_SIZES; s++) begin : g_sz
    localparam int W     = 8 << s;
    localparam int PAIRS = DATA_W / (2 * W);

    logic [DATA_W-1:0] r_all;

    for (genvar j = 0; j < PAIRS; j++) begin : g_pr
      localparam int UP = (2 * j + 1) * W;
      localparam int DN = (2 * j) * W;
      assign r_all[UP +: W] = take_hi ? a[UP +: W] : a[DN +: W];
      assign r_all[DN +: W] = take_hi ? b[UP +: W] : b[DN +: W];
    end

    assign by_size[s] = r_all;
  end

  always_comb begin
    if (size == 2'd3) y = '0;
    else              y = by_size[size];
  end

endmodule

// File: rtl/ssp_permute.sv
`timescale 1ns/1ps
// Register-driven lane permute with repetition, byte or 2-byte lanes.
module ssp_permute #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] sel,
  input  logic              byte_mode,
  output logic [DATA_W-1:0] y
);
  localparam int NB  = DATA_W / 8;
  localparam int BIW = $clog2(NB);
  localparam int NH  = DATA_W / 16;
  localparam int HIW = $clog2(NH);

  logic [DATA_W-1:0] byte_res;
  logic [DATA_W-1:0] half_res;

  for (genvar i = 0; i < NB; i++) begin : g_b
    logic [BIW-1:0]    idx;
    logic [DATA_W-1:0] moved;
    assign idx                 = sel[i*BIW +: BIW];
    assign moved               = a >> {idx, 3'b000};
    assign byte_res[i*8 +: 8]  = moved[7:0];
  end

  for (genvar i = 0; i < NH; i++) begin : g_h
    logic [HIW-1:0]    idx;
    logic [DATA_W-1:0] moved;
    assign idx                  = sel[i*HIW +: HIW];
    assign moved                = a >> {idx, 4'b0000};
    assign half_res[i*16 +: 16] = moved[15:0];
  end

  assign y = byte_mode ? byte_res : half_res;

endmodule

// File: rtl/ssp_unit.sv
`timescale 1ns/1ps
module ssp_unit
  import ssp_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [OP_W-1:0]   in_op,
  input  logic [SIZE_W-1:0] in_size,
  input  logic [SH_W-1:0]   in_imm,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  ssp_op_e           op;
  logic              sh_left;
  logic              sh_arith;
  logic              sh_var;
  logic [DATA_W-1:0] shift_y;
  logic [DATA_W-1:0] funnel_y;
  logic [DATA_W-1:0] mix_y;
  logic [DATA_W-1:0] perm_y;
  logic [DATA_W-1:0] result;
  logic              accept;

  assign op = ssp_op_e'(in_op);

  always_comb begin
    sh_left  = (op == OP_SHL_I) || (op == OP_SHL_V);
    sh_arith = (op == OP_SAR_I) || (op == OP_SAR_V);
    sh_var   = (op == OP_SHL_V) || (op == OP_SHR_V) || (op == OP_SAR_V);
  end

  ssp_lane_shift #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
    .a       (in_a),
    .b       (in_b),
    .imm     (in_imm),
    .size    (in_size),
    .go_left (sh_left),
    .arith   (sh_arith),
    .use_var (sh_var),
    .y       (shift_y)
  );

  ssp_funnel #(.DATA_W(DATA_W), .SH_W(SH_W)) u_funnel (
    .hi  (in_a),
    .lo  (in_b),
    .amt (in_imm),
    .y   (funnel_y)
  );

  ssp_mix #(.DATA_W(DATA_W)) u_mix (
    .a       (in_a),
    .b       (in_b),
    .size    (in_size),
    .take_hi (op == OP_MIX_HI),
    .y       (mix_y)
  );

  ssp_permute #(.DATA_W(DATA_W)) u_perm (
    .a         (in_a),
    .sel       (in_b),
    .byte_mode (in_size == LS_B1),
    .y         (perm_y)
  );

  always_comb begin
    unique case (op)
      OP_SHL_I, OP_SHR_I, OP_SAR_I,
      OP_SHL_V, OP_SHR_V, OP_SAR_V: result = shift_y;
      OP_FUNNEL:                    result = funnel_y;
      OP_MIX_HI, OP_MIX_LO:         result = mix_y;
      OP_PERM:                      result = perm_y;
      default:                      result = '0;
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (accept)   out_data  <= result;
    end
  end

endmodule

// File: rtl/ssp_unit_chk.sv
`timescale 1ns/1ps
module ssp_unit_chk #(
  parameter int DATA_W = 64,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_a,
  input logic [DATA_W-1:0] in_b,
  input logic [3:0]        in_op,
  input logic [1:0]        in_size,
  input logic [SH_W-1:0]   in_imm,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data
);
  logic              fire;
  logic [SH_W:0]     lane_w;
  logic [DATA_W-1:0] rot_probe;
  logic [DATA_W-1:0] perm_probe;

  assign fire       = in_valid && in_ready;
  assign lane_w     = (SH_W+1)'(8) << in_size;
  assign rot_probe  = (in_a >> in_imm) | (in_a << ((SH_W+1)'(DATA_W) - {1'b0, in_imm}));
  assign perm_probe = in_a >> {in_b[2:0], 3'b000};

  assert_oversize_left_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == 4'd0 && {1'b0, in_imm} >= lane_w |=> out_data == '0);

  assert_rotate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == 4'd6 && in_a == in_b |=> out_data == $past(rot_probe));

  assert_perm_byte0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == 4'd9 && in_size == 2'd0 |=> out_data[7:0] == $past(perm_probe[7:0]));

  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_reset_R12: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

endmodule

bind ssp_unit ssp_unit_chk #(.DATA_W(DATA_W), .SH_W(SH_W)) u_chk (.*);

// File: tb/ssp_unit_bench.sv
`timescale 1ns/1ps
module ssp_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic [3:0]  in_op = '0;
  logic [1:0]  in_size = '0;
  logic [5:0]  in_imm = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit bp_en  = 1'b0;
  bit done   = 1'b0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  ssp_unit u_ssp_unit (.*);

  function automatic logic [63:0] model(input logic [3:0] op, input logic [1:0] sz,
                                        input logic [63:0] a, input logic [63:0] b,
                                        input logic [5:0] imm);
    logic [63:0]  res;
    logic [127:0] cat;
    int w, n;
    logic [63:0] mask;
    res  = '0;
    w    = 8 << sz;
    n    = 64 / w;
    mask = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
    if (op <= 4'd5) begin
      for (int l = 0; l < n; l++) begin
        logic [63:0] av, amt, r, sv;
        av  = (a >> (l * w)) & mask;
        amt = (op < 4'd3) ? 64'(imm) : ((b >> (l * w)) & mask);
        if (op == 4'd0 || op == 4'd3)
          r = (amt >= 64'(w)) ? 64'd0 : ((av << amt) & mask);
        else if (op == 4'd1 || op == 4'd4)
          r = (amt >= 64'(w)) ? 64'd0 : (av >> amt);
        else begin
          sv = av[w-1] ? (av | ~mask) : av;
          if (amt >= 64'(w)) r = av[w-1] ? mask : 64'd0;
          else r = 64'($signed(sv) >>> amt) & mask;
        end
        res |= r << (l * w);
      end
    end else if (op == 4'd6) begin
      cat = {a, b} >> imm;
      res = cat[63:0];
    end else if (op == 4'd7 || op == 4'd8) begin
      if (w != 64) begin
        for (int j = 0; j < n / 2; j++) begin
          int src;
          src = (op == 4'd7) ? 2 * j + 1 : 2 * j;
          res |= ((a >> (src * w)) & mask) << ((2 * j + 1) * w);
          res |= ((b >> (src * w)) & mask) << ((2 * j) * w);
        end
      end
    end else if (op == 4'd9) begin
      if (sz == 2'd0) begin
        for (int i = 0; i < 8; i++) begin
          int idx;
          idx = int'((b >> (3 * i)) & 64'd7);
          res |= ((a >> (8 * idx)) & 64'hFF) << (8 * i);
        end
      end else begin
        for (int i = 0; i < 4; i++) begin
          int idx;
          idx = int'((b >> (2 * i)) & 64'd3);
          res |= ((a >> (16 * idx)) & 64'hFFFF) << (16 * i);
        end
      end
    end
    return res;
  endfunction

  function automatic string tag_of(input logic [3:0] op, input logic [63:0] a,
                                   input logic [63:0] b);
    case (op)
      4'd0, 4'd1: return "R1";
      4'd2:       return "R2";
      4'd3, 4'd4, 4'd5: return "R3";
      4'd6:       return (a == b) ? "R5" : "R4";
      4'd7:       return "R6";
      4'd8:       return "R7";
      4'd9:       return "R8";
      default:    return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the reference queue.
  logic        prev_fire  = 1'b0;
  logic        prev_stall = 1'b0;
  logic [63:0] prev_data  = '0;
  always @(negedge clk) begin
    if (!rst_n) begin
      check("R12", {63'd0, out_valid}, 64'd0);
      prev_fire  <= 1'b0;
      prev_stall <= 1'b0;
    end else begin
      if (prev_fire)  check("R10", {63'd0, out_valid}, 64'd1);
      if (prev_stall) begin
        check("R11", {63'd0, out_valid}, 64'd1);
        check("R11", out_data, prev_data);
      end
      if (out_valid) begin
        if (exp_q.size() == 0) check("R10", 64'd1, 64'd0);
        else check(tag_q[0], out_data, exp_q[0]);
        if (out_ready && exp_q.size() != 0) begin
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
      end
      if (in_valid && in_ready) begin
        exp_q.push_back(model(in_op, in_size, in_a, in_b, in_imm));
        tag_q.push_back(tag_of(in_op, in_a, in_b));
      end
      prev_fire  <= in_valid && in_ready;
      prev_stall <= out_valid && !out_ready;
      prev_data  <= out_data;
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = bp_en ? ($urandom_range(0, 3) != 0) : 1'b1;
    end
  end

  task automatic issue(input logic [3:0] op, input logic [1:0] sz, input logic [63:0] a,
                       input logic [63:0] b, input logic [5:0] imm);
    @(posedge clk); #1;
    in_op = op; in_size = sz; in_a = a; in_b = b; in_imm = imm; in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic exec(input logic [3:0] op, input logic [1:0] sz, input logic [63:0] a,
                      input logic [63:0] b, output logic [63:0] res);
    issue(op, sz, a, b, 6'd0);
    @(negedge clk);
    while (!out_valid) @(negedge clk);
    res = out_data;
  endtask

  task automatic tr4(input logic [63:0] w0, input logic [63:0] w1, input logic [63:0] w2,
                     input logic [63:0] w3, output logic [63:0] o0, output logic [63:0] o1,
                     output logic [63:0] o2, output logic [63:0] o3);
    logic [63:0] t0, t1, t2, t3;
    exec(4'd7, 2'd1, w0, w1, t0);
    exec(4'd8, 2'd1, w0, w1, t1);
    exec(4'd7, 2'd1, w2, w3, t2);
    exec(4'd8, 2'd1, w2, w3, t3);
    exec(4'd7, 2'd2, t0, t2, o0);
    exec(4'd7, 2'd2, t1, t3, o1);
    exec(4'd8, 2'd2, t0, t2, o2);
    exec(4'd8, 2'd2, t1, t3, o3);
  endtask

  // R13: 8x8 block of 16-bit values, row r = {L[r], R[r]}, column 0 in the top lane.
  task automatic transpose_test();
    logic [15:0] m [8][8];
    logic [63:0] lw [8];
    logic [63:0] rw [8];
    logic [63:0] ol [8];
    logic [63:0] orr [8];
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++)
        m[r][c] = 16'(r * 16'h0100 + c + 16'h1000 * (r ^ c));
    for (int r = 0; r < 8; r++) begin
      lw[r] = {m[r][0], m[r][1], m[r][2], m[r][3]};
      rw[r] = {m[r][4], m[r][5], m[r][6], m[r][7]};
    end
    tr4(lw[0], lw[1], lw[2], lw[3], ol[0], ol[1], ol[2], ol[3]);
    tr4(lw[4], lw[5], lw[6], lw[7], orr[0], orr[1], orr[2], orr[3]);
    tr4(rw[0], rw[1], rw[2], rw[3], ol[4], ol[5], ol[6], ol[7]);
    tr4(rw[4], rw[5], rw[6], rw[7], orr[4], orr[5], orr[6], orr[7]);
    for (int r = 0; r < 8; r++) begin
      check("R13", ol[r],  {m[0][r], m[1][r], m[2][r], m[3][r]});
      check("R13", orr[r], {m[4][r], m[5][r], m[6][r], m[7][r]});
    end
  endtask

  initial begin
    logic [63:0] res;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // Directed corners (checked by the monitor against the model)
    issue(4'd0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, '0, 6'd8);   // R1 oversize -> 0
    issue(4'd1, 2'd1, 64'h8001_7FFE_FFFF_1234, '0, 6'd15);  // R1 just below width
    issue(4'd2, 2'd0, 64'h80_7F_FF_01_C0_40_81_00, '0, 6'd7); // R2
    issue(4'd2, 2'd2, 64'h8000_0000_7FFF_FFFF, '0, 6'd40);  // R2 oversize -> sign fill
    issue(4'd3, 2'd0, 64'h0101_0101_0101_0101, 64'h0009_0807_0302_0100, 6'd0); // R3
    issue(4'd5, 2'd1, 64'h8000_8000_8000_8000, 64'hFF0F_0010_000F_0001, 6'd0); // R3
    issue(4'd4, 2'd3, 64'hF000_0000_0000_0000, 64'd63, 6'd0); // R3 8-byte
    issue(4'd6, 2'd0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 6'd0);  // R4
    issue(4'd6, 2'd0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 6'd63); // R4
    issue(4'd6, 2'd0, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 6'd12); // R5
    issue(4'd7, 2'd0, 64'h0706_0504_0302_0100, 64'h1716_1514_1312_1110, 6'd0); // R6
    issue(4'd8, 2'd2, 64'h0706_0504_0302_0100, 64'h1716_1514_1312_1110, 6'd0); // R7
    issue(4'd7, 2'd3, 64'h0706_0504_0302_0100, 64'h1716_1514_1312_1110, 6'd0); // R7 8-byte -> 0
    issue(4'd9, 2'd0, 64'h8877_6655_4433_2211, 64'h0000_0000_0000_0000, 6'd0); // R8 repeat
    issue(4'd9, 2'd1, 64'h4444_3333_2222_1111, 64'h0000_0000_0000_001B, 6'd0); // R8 reverse
    issue(4'd15, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, '1, 6'd3);  // R9 undefined
    issue(4'd12, 2'd2, 64'h1234, 64'h5678, 6'd1);          // R9 undefined

    // Explicit R5 rotate check with a hand-computed value
    exec(4'd6, 2'd0, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, res);
    check("R5", res, 64'h0123_4567_89AB_CDEF);
    issue(4'd6, 2'd0, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 6'd8);
    @(negedge clk);
    while (!out_valid) @(negedge clk);
    check("R5", out_data, 64'hEF01_2345_6789_ABCD);

    // Random traffic under back-pressure
    bp_en = 1'b1;
    for (int k = 0; k < 1500; k++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = ($urandom_range(0, 3) == 0) ? a : {$urandom, $urandom};
      if ($urandom_range(0, 1) == 0) b = b & 64'h0707_0707_0707_0707;
      issue(4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)), a, b,
            6'($urandom_range(0, 63)));
    end
    bp_en = 1'b0;
    repeat (6) @(posedge clk);

    transpose_test();
    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired got=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule